// File: doc/BRIEF.md
# SPI Master Burst Transfer Controller

This block runs SPI master transfers under a small control register. A single configuration write loads four things at once: an enable bit, a transfer mode, a chip-select index and an 8-bit frame count. Once enabled, the controller takes words from an external transmit FIFO and shifts each one out, most significant bit first. Each received word goes to an external receive FIFO. One of four active-low chip selects is held asserted for the whole burst.

The frame count selects the kind of run. A value of 0 runs without limit until software writes the enable bit low. A value of 1 runs a single frame, and a value N from 2 to 255 runs a burst of N frames. After a counted run the controller clears its own enable bit. When software clears the enable bit during a frame, that frame still completes before the controller stops. In receive-only mode the controller starts at once and drives MOSI high. In the modes that transmit, it starts a frame only when the transmit FIFO holds a word. Software watches the busy flag: it must be low before the next burst is enabled.

Top module: `spi_burst_ctrl`

## Requirements
- R1: After reset: en_o=0, busy_o=0, ovr_o=0, every cs_no bit is 1, sclk_o=0 and mosi_o=1.
- R2: A count of 0 runs frames without limit and leaves en_o at 1. A count of 1 runs exactly one frame, and a count N from 2 to 255 runs exactly N frames. After a counted run, en_o returns to 0 without a write.
- R3: In modes 01 and 11 a frame starts only when tx_empty_i=0, and it pops exactly one word. With the transmit FIFO empty, nothing starts and busy_o stays 0 until data arrives.
- R4: In mode 10 frames start as soon as the controller is enabled, without transmit data, and every shifted MOSI bit is 1.
- R5: Writing en=0 during a frame lets that frame finish all DW bits. No further frame starts, and busy_o then drops.
- R6: The mode field is decoded as 01 = transmit only (rx_push_o never asserts), 10 = receive only (tx_pop_o never asserts), 11 = full duplex and 00 = reserved (no frame starts).
- R7: busy_o rises with the first frame of a run and stays high through any wait for transmit data between frames. It falls on the cycle after the last frame's final SCLK-high cycle.
- R8: A chip-select field of value k (0 to 3) drives cs_no[k] low while busy_o=1. All other chip selects stay high, and all are high while idle.
- R9: Each bit takes two clock cycles, SCLK low and then SCLK high, with SCLK idle low. MOSI is MSB first and changes only on SCLK falling edges. MISO is sampled on rising edges. While busy_o=0, sclk_o=0 and mosi_o=1.
- R10: If rx_full_i=1 when a frame ends in mode 10 or 11, the word is dropped (rx_push_o stays 0) and ovr_o is set. ovr_o stays set until the next configuration write.
- R11: With cfg_we_i=1, all fields load on that clock edge. The new enable takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable bit value to write |
| cfg_mode_i | input | 2 | Transfer mode to write |
| cfg_cs_i | input | 2 | Chip-select index to write |
| cfg_count_i | input | 8 | Frame count to write |
| en_o | output | 1 | Current enable bit |
| busy_o | output | 1 | Run in progress |
| ovr_o | output | 1 | Sticky receive overrun |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_data_i | input | 8 | Transmit FIFO head word |
| tx_pop_o | output | 1 | Transmit FIFO pop |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_data_o | output | 8 | Received word |
| rx_push_o | output | 1 | Receive FIFO push |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Active-low chip selects |

## Verification
The assertions check on every cycle that the FIFO handshakes respect empty and full, and that the mode gating blocks pops in receive-only mode and pushes in transmit-only mode. They also check that at most one chip select is low, that the lines idle when the controller is not busy, and that the enable bit falls only at a frame end or on a write. Only the bench scenarios can show the rest: the number of frames in each run, the bit order of words on the wire, completion of a frame after a mid-frame disable, the hold while waiting for data in continuous mode, and the drop of received words on overrun.

// File: rtl/spi_burst_ctrl_pkg.sv
package spi_burst_ctrl_pkg;
  typedef enum logic [1:0] {
    XM_RSVD = 2'b00,
    XM_TX   = 2'b01,
    XM_RX   = 2'b10,
    XM_FDX  = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8,
  localparam int BW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] tx_word_i,
  input  logic          miso_i,
  output logic          run_o,
  output logic          done_o,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic [DW-1:0] rx_word_o
);
  logic [DW-1:0] tx_sh, rx_sh;
  logic [BW-1:0] bit_q;
  logic          ph_q, run_q;

  assign done_o    = run_q & ph_q & (bit_q == '0);
  assign run_o     = run_q;
  assign sclk_o    = run_q & ph_q;
  assign mosi_o    = tx_sh[DW-1];
  assign rx_word_o = rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh <= '1;
      rx_sh <= '0;
      bit_q <= '0;
      ph_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (load_i) begin
      run_q <= 1'b1;
      ph_q  <= 1'b0;
      bit_q <= BW'(DW - 1);
      tx_sh <= tx_word_i;
    end else if (run_q) begin
      if (!ph_q) begin
        ph_q  <= 1'b1;                       // rising edge: sample
        rx_sh <= {rx_sh[DW-2:0], miso_i};
      end else if (bit_q == '0) begin
        run_q <= 1'b0;
        ph_q  <= 1'b0;
        tx_sh <= '1;
      end else begin
        ph_q  <= 1'b0;                       // falling edge: shift
        bit_q <= bit_q - 1'b1;
        tx_sh <= {tx_sh[DW-2:0], 1'b1};
      end
    end
  end

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !run_q); // R9
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !ph_q && !load_i) |=> $stable(mosi_o)); // R9
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_burst_ctrl_pkg::*;
#(
  parameter int CW = 8,
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_en_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic [SW-1:0] cfg_cs_i,
  input  logic [CW-1:0] cfg_count_i,
  input  logic          tx_empty_i,
  input  logic          rx_full_i,
  input  logic          run_i,
  input  logic          done_i,
  output logic          load_o,
  output logic          tx_pop_o,
  output logic          tx_path_o,
  output logic          rx_push_o,
  output logic          en_o,
  output logic          busy_o,
  output logic          ovr_o,
  output logic [SW-1:0] cs_sel_o
);
  logic          en_q, act_q, ovr_q;
  xfer_mode_e    mode_q;
  logic [SW-1:0] cs_q;
  logic [CW-1:0] cnt_q, done_q;
  logic          tx_used, rx_used, start, last;

  assign tx_used = (mode_q == XM_TX) || (mode_q == XM_FDX);
  assign rx_used = (mode_q == XM_RX) || (mode_q == XM_FDX);
  assign start   = en_q && !run_i && ((mode_q == XM_RX) || (tx_used && !tx_empty_i));
  assign last    = (cnt_q != '0) && (done_q == cnt_q - 1'b1);

  assign load_o    = start;
  assign tx_pop_o  = start && tx_used;
  assign tx_path_o = tx_used;
  assign rx_push_o = done_i && rx_used && !rx_full_i;
  assign en_o      = en_q;
  assign busy_o    = act_q;
  assign ovr_o     = ovr_q;
  assign cs_sel_o  = cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      ovr_q  <= 1'b0;
      mode_q <= XM_FDX;
      cs_q   <= '0;
      cnt_q  <= CW'(1);
      done_q <= '0;
    end else begin
      if (start) act_q <= 1'b1;
      if (done_i) begin
        if (last) begin
          en_q   <= 1'b0;
          act_q  <= 1'b0;
          done_q <= '0;
        end else if (!en_q) begin
          act_q  <= 1'b0;
          done_q <= '0;
        end else begin
          done_q <= done_q + 1'b1;
        end
      end else if (act_q && !run_i && !en_q) begin
        act_q  <= 1'b0;                     // disabled while waiting for data
        done_q <= '0;
      end
      if (done_i && rx_used && rx_full_i) ovr_q <= 1'b1;
      if (cfg_we_i) begin                   // a write wins over auto-clear
        en_q   <= cfg_en_i;
        mode_q <= xfer_mode_e'(cfg_mode_i);
        cs_q   <= cfg_cs_i;
        cnt_q  <= cfg_count_i;
        ovr_q  <= 1'b0;
      end
    end
  end

  AST_POP_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i); // R3
  AST_RX_ONLY_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == XM_RX) |-> !tx_pop_o); // R6
  AST_TX_ONLY_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == XM_TX) |-> !rx_push_o); // R6
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !rx_full_i); // R10
  AST_AUTO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(en_q) && !$past(cfg_we_i)) |-> $past(done_i)); // R2
  AST_RUN_IS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> act_q); // R7
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> ($past(done_i) || !$past(en_q))); // R5
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_ctrl_pkg::*;
#(
  parameter int DW  = 8,
  parameter int CW  = 8,
  parameter int NCS = 4,
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic           cfg_en_i,
  input  logic [1:0]     cfg_mode_i,
  input  logic [SW-1:0]  cfg_cs_i,
  input  logic [CW-1:0]  cfg_count_i,
  output logic           en_o,
  output logic           busy_o,
  output logic           ovr_o,
  input  logic           tx_empty_i,
  input  logic [DW-1:0]  tx_data_i,
  output logic           tx_pop_o,
  input  logic           rx_full_i,
  output logic [DW-1:0]  rx_data_o,
  output logic           rx_push_o,
  output logic           sclk_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_no
);
  logic          load, run, done, tx_path;
  logic [SW-1:0] cs_sel;

  spi_frame_seq #(.CW(CW), .SW(SW)) u_seq (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_en_i, .cfg_mode_i, .cfg_cs_i, .cfg_count_i,
    .tx_empty_i, .rx_full_i,
    .run_i     (run),
    .done_i    (done),
    .load_o    (load),
    .tx_pop_o,
    .tx_path_o (tx_path),
    .rx_push_o, .en_o, .busy_o, .ovr_o,
    .cs_sel_o  (cs_sel)
  );

  spi_shifter #(.DW(DW)) u_shift (
    .clk_i, .rst_ni,
    .load_i    (load),
    .tx_word_i (tx_path ? tx_data_i : '1),
    .miso_i,
    .run_o     (run),
    .done_o    (done),
    .sclk_o, .mosi_o,
    .rx_word_o (rx_data_o)
  );

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_no[i] = !(busy_o && (cs_sel == SW'(i)));
  end

  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1); // R8
  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && mosi_o)); // R9
endmodule

// File: tb/spi_burst_ctrl_test.sv
module spi_burst_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 0, cfg_en_i = 0;
  logic [1:0] cfg_mode_i = 2'b11, cfg_cs_i = 0;
  logic [7:0] cfg_count_i = 8'd1;
  logic en_o, busy_o, ovr_o, tx_pop_o, rx_push_o, sclk_o, mosi_o, miso_i;
  logic tx_empty_i = 1'b1, rx_full_i = 1'b0;
  logic [7:0] tx_data_i = 0, rx_data_o;
  logic [3:0] cs_no;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_burst_ctrl uut (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_en_i, .cfg_mode_i, .cfg_cs_i, .cfg_count_i,
    .en_o, .busy_o, .ovr_o, .tx_empty_i, .tx_data_i, .tx_pop_o,
    .rx_full_i, .rx_data_o, .rx_push_o, .sclk_o, .mosi_o, .miso_i, .cs_no
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] txq[$], rxq[$], wire_q[$], sent_q[$], pushed[$];
  int exp_sel = 0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // slave device model
  logic [7:0] s_sh, s_cap = 0, s_word;
  int s_bits = 0, s_idx = 0;
  function automatic logic [7:0] slave_word(int k);
    return 8'(8'h3C ^ (k * 37));
  endfunction
  initial begin s_word = slave_word(0); s_sh = s_word; end
  assign miso_i = s_sh[7];
  always @(posedge sclk_o) if (rst_ni) begin
    s_cap = {s_cap[6:0], mosi_o};
    s_bits++;
  end
  always @(negedge sclk_o) if (rst_ni) begin
    if (s_bits == DW) begin
      wire_q.push_back(s_cap);
      sent_q.push_back(s_word);
      s_idx++;
      s_word = slave_word(s_idx);
      s_sh = s_word;
      s_bits = 0;
    end else s_sh = {s_sh[6:0], 1'b0};
  end

  // FIFO models and per-clock reference checks
  logic pend_pop = 0, pend_push = 0;
  logic [7:0] pend_rx = 0;
  always @(negedge clk) begin
    if (pend_pop && txq.size() > 0) void'(txq.pop_front());
    if (pend_push) rxq.push_back(pend_rx);
    tx_empty_i = (txq.size() == 0);
    tx_data_i  = (txq.size() == 0) ? 8'h00 : txq[0];
    #1;
    pend_pop  = tx_pop_o;
    pend_push = rx_push_o;
    pend_rx   = rx_data_o;
    if (rst_ni) begin
      check("R8", "cs per cycle", cs_no, busy_o ? (~(4'b1 << exp_sel) & 4'hF) : 4'hF);
      if (!busy_o) check("R9", "idle lines", {sclk_o, mosi_o}, 2'b01);
    end
  end

  task automatic cfg(bit en, logic [1:0] mode, int cs, int cnt);
    @(posedge clk); #2;
    cfg_we_i = 1; cfg_en_i = en; cfg_mode_i = mode; cfg_cs_i = 2'(cs); cfg_count_i = 8'(cnt);
    exp_sel = cs;
    @(posedge clk); #2;
    cfg_we_i = 0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic push_tx(logic [7:0] w);
    txq.push_back(w);
    pushed.push_back(w);
  endtask

  task automatic fresh();
    wire_q.delete(); sent_q.delete(); rxq.delete(); pushed.delete();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cycles(3);
    rst_ni = 1;
    #1;
    check("R1", "reset outputs", {en_o, busy_o, ovr_o, sclk_o, mosi_o}, 5'b00001);
    check("R1", "reset cs", cs_no, 4'hF);
    cycles(2);

    // full duplex burst of 3, cs 2
    fresh();
    for (int i = 0; i < 5; i++) push_tx(8'hA1 + 8'(i * 17));
    cfg(1, 2'b11, 2, 3);
    cycles(6);
    check("R7", "busy during burst", busy_o, 1);
    check("R8", "cs2 low", cs_no, 4'b1011);
    check("R11", "enable loaded", en_o, 1);
    cycles(70);
    check("R2", "burst frames", wire_q.size(), 3);
    for (int i = 0; i < 3 && i < wire_q.size(); i++)
      check("R9", "mosi word msb first", wire_q[i], pushed[i]);
    check("R9", "rx count", rxq.size(), 3);
    for (int i = 0; i < 3 && i < rxq.size() && i < sent_q.size(); i++)
      check("R9", "miso word", rxq[i], sent_q[i]);
    check("R2", "en auto clear", en_o, 0);
    check("R7", "busy low after burst", busy_o, 0);
    check("R3", "one pop per frame", txq.size(), 2);

    // transmit-only single, cs 1
    txq.delete(); fresh();
    push_tx(8'h5A); push_tx(8'hC3);
    cfg(1, 2'b01, 1, 1);
    cycles(6);
    check("R8", "cs1 low", cs_no, 4'b1101);
    cycles(34);
    check("R2", "single frame", wire_q.size(), 1);
    if (wire_q.size() > 0) check("R6", "tx only word", wire_q[0], 8'h5A);
    check("R6", "tx only no push", rxq.size(), 0);
    check("R2", "single en clear", en_o, 0);
    check("R3", "tx left", txq.size(), 1);

    // receive-only burst of 2, cs 0
    fresh();
    cfg(1, 2'b10, 0, 2);
    cycles(60);
    check("R4", "rx only frames", wire_q.size(), 2);
    for (int i = 0; i < wire_q.size(); i++) check("R4", "mosi ones", wire_q[i], 8'hFF);
    check("R6", "rx only no pop", txq.size(), 1);
    check("R4", "rx pushes", rxq.size(), 2);
    if (rxq.size() == 2 && sent_q.size() >= 2) check("R4", "rx word", rxq[1], sent_q[1]);
    check("R2", "rx burst en clear", en_o, 0);

    // continuous, cs 3
    txq.delete(); fresh();
    for (int i = 0; i < 4; i++) push_tx(8'h10 + 8'(i));
    cfg(1, 2'b11, 3, 0);
    cycles(100);
    check("R2", "continuous frames", wire_q.size(), 4);
    check("R2", "continuous en stays", en_o, 1);
    check("R7", "busy while waiting", busy_o, 1);
    check("R7", "cs held waiting", cs_no, 4'b0111);
    push_tx(8'h77);
    cycles(30);
    check("R3", "frame after data", wire_q.size(), 5);
    push_tx(8'hE4); push_tx(8'h99);
    cycles(5);
    cfg(0, 2'b11, 3, 0);
    check("R5", "busy mid frame", busy_o, 1);
    cycles(40);
    check("R5", "frame completes", wire_q.size(), 6);
    if (wire_q.size() == 6) check("R5", "completed word", wire_q[5], 8'hE4);
    check("R5", "stopped", busy_o, 0);
    check("R5", "no further pop", txq.size(), 1);

    // overrun
    txq.delete(); fresh();
    rx_full_i = 1;
    push_tx(8'h01); push_tx(8'h02);
    cfg(1, 2'b11, 0, 2);
    cycles(60);
    check("R10", "frames with full rx", wire_q.size(), 2);
    check("R10", "no push when full", rxq.size(), 0);
    check("R10", "overrun set", ovr_o, 1);
    rx_full_i = 0;
    cycles(5);
    check("R10", "overrun sticky", ovr_o, 1);
    cfg(0, 2'b11, 0, 1);
    #1;
    check("R10", "overrun cleared", ovr_o, 0);

    // reserved mode
    fresh();
    push_tx(8'h42);
    cfg(1, 2'b00, 0, 1);
    cycles(50);
    check("R6", "reserved no frame", wire_q.size(), 0);
    check("R6", "reserved no busy", busy_o, 0);
    check("R6", "reserved no pop", txq.size(), 1);
    cfg(0, 2'b11, 0, 1);

    // empty tx waits
    txq.delete(); fresh();
    cfg(1, 2'b11, 1, 1);
    cycles(40);
    check("R3", "no start when empty", wire_q.size(), 0);
    check("R3", "busy low when empty", busy_o, 0);
    check("R3", "en held", en_o, 1);
    push_tx(8'h96);
    cycles(30);
    check("R3", "starts on data", wire_q.size(), 1);
    if (wire_q.size() == 1) check("R3", "word", wire_q[0], 8'h96);
    check("R2", "single done", en_o, 0);
    check("R7", "idle after", busy_o, 0);

    cycles(5);
    finish_run();
  end
endmodule